// File: doc/BRIEF.md
# Dual-Direction Byte Mailbox Exchange

This block holds one shared 32-bit exchange word between a host processor and an embedded device controller. Single bytes are moved across it in both directions. Each direction has its own typed four-phase handshake channel. The host starts typed requests: it either pushes a data byte to the device or asks the device for a reply byte. The device starts typed unsolicited posts, such as a diagnostic character, an interrupt cause or a completion code, and the host acknowledges each one.

Each side has a plain write strobe with a 32-bit write word and a continuously readable 32-bit view. A side sees its own request bit reflected as the other side's acknowledgement, so the usual pattern is: set, wait for set, clear, wait for clear. Type codes are split by initiator. Codes 0 to 63 belong to the host and codes 64 to 127 belong to the device. A request with a type code from the other side's range is refused.

Each channel has a timer that runs while the initiator is waiting on the responder. The timer raises a sticky timeout flag when the wait passes the selected limit. A longer limit applies while `slow_link` is high. A one-cycle pulse tells each side that the other side has raised a request.

Each channel runs four named states:
- CH_IDLE: the channel is free.
- CH_REQ: the request is raised and the initiator is waiting for the acknowledgement.
- CH_ACK: the acknowledgement has been seen and the channel is waiting for the initiator to withdraw its request.
- CH_DROP: the request is withdrawn and the channel is waiting for the acknowledgement to fall.

The transitions are:
- start: CH_IDLE to CH_REQ, on a request write whose type code is in range.
- accept: CH_REQ to CH_ACK, when the acknowledgement is high.
- withdraw: CH_ACK to CH_DROP, on a write with the request bit low.
- release: CH_DROP to CH_IDLE, when the acknowledgement is low.

Top module: `mailbox_xchg`

## Requirements
- R1: After reset, both read views are zero and all pulse, error and timeout outputs are low.
- R2: A host write received in CH_IDLE latches `host_wdata[6:0]` as the host type and `host_wdata[15:8]` as the host data. If `host_wdata[7]` is 1 and the type is below 64, the request starts. From the next cycle the device view shows `dev_rdata[7]`=1, `dev_rdata[6:0]`=type and `dev_rdata[15:8]`=data.
- R3: `host_rdata[7]` shows the device acknowledgement bit, which is written from `dev_wdata[7]`. `host_rdata[15:8]` shows the reply byte, which is written from `dev_wdata[15:8]`. Both are updated on every device write.
- R4: A raised request stays raised until the initiator writes its request bit low. A low request bit written before the acknowledgement arrives is ignored. The channel returns to CH_IDLE only after the acknowledgement has fallen.
- R5: While a channel is not in CH_IDLE, the initiator's writes do not change the latched type or data.
- R6: A device write received in CH_IDLE latches `dev_wdata[22:16]` as the device type and `dev_wdata[31:24]` as the device data. If `dev_wdata[23]` is 1 and the type is 64 or above, the request starts. The host view then shows bit 23 = 1, bits 22:16 = type and bits 31:24 = data.
- R7: `host_wdata[23]` is the host acknowledgement of the device channel, seen at `dev_rdata[23]`. The device channel completes the same four-phase sequence against this bit.
- R8: A request write with a type code in the other initiator's range sets that side's sticky error flag (`host_err` or `dev_err`). The request bit is not raised.
- R9: With `slow_link` low, a channel left waiting in CH_REQ or CH_DROP for more than `LIM_FAST` cycles sets its sticky timeout flag.
- R10: With `slow_link` high, the limit is `LIM_SLOW` cycles instead.
- R11: `dev_req_pulse` and `host_evt_pulse` are high for exactly one cycle, in the first cycle the host request or the device request reads as raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_link | input | 1 | Selects the long wait limit |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read view |
| dev_wr | input | 1 | Device write strobe |
| dev_wdata | input | 32 | Device write word |
| dev_rdata | output | 32 | Device read view |
| dev_req_pulse | output | 1 | Host request has just risen |
| host_evt_pulse | output | 1 | Device request has just risen |
| host_err | output | 1 | Sticky: host used an out-of-range type |
| dev_err | output | 1 | Sticky: device used an out-of-range type |
| host_tmo | output | 1 | Sticky: host channel wait timed out |
| dev_tmo | output | 1 | Sticky: device channel wait timed out |

## Verification
The bench builds the block with `LIM_FAST`=40 and `LIM_SLOW`=200 in place of the millisecond-scale defaults. This lets both timeout limits be reached, and the slow limit be shown not to fire at a wait that already exceeds the fast one, within a few hundred cycles. With these small limits, randomized complete transactions in both directions still finish far inside either window.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int TYPE_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int SPLIT_TYPE = 64;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_REQ,
        CH_ACK,
        CH_DROP
    } ch_state_t;
endpackage

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
    parameter int LIM_FAST = 2_500_000,
    parameter int LIM_SLOW = 55_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic waiting,
    input  logic restart,
    output logic tmo
);
    localparam int CW = $clog2(LIM_SLOW + 1);
    localparam logic [CW-1:0] LF = CW'(LIM_FAST);
    localparam logic [CW-1:0] LS = CW'(LIM_SLOW);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim = slow ? LS : LF;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmo   <= 1'b0;
        end else if (restart || !waiting) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim) begin
            tmo   <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> tmo); // R9
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
#(
    parameter bit DEV_INIT = 1'b0,
    parameter int LIM_FAST = 2_500_000,
    parameter int LIM_SLOW = 55_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow,
    input  logic              wr,
    input  logic              wr_req,
    input  logic [TYPE_W-1:0] wr_type,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ack,
    output logic              req,
    output logic [TYPE_W-1:0] type_q,
    output logic [BYTE_W-1:0] data_q,
    output logic              rise,
    output logic              err,
    output logic              tmo
);
    ch_state_t st, st_nx;
    logic      type_ok;
    logic      req_d;

    generate
        if (DEV_INIT) begin : g_dev_range
            assign type_ok = (wr_type >= TYPE_W'(SPLIT_TYPE));
        end else begin : g_host_range
            assign type_ok = (wr_type < TYPE_W'(SPLIT_TYPE));
        end
    endgenerate

    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE: if (wr && wr_req && type_ok) st_nx = CH_REQ;
            CH_REQ:  if (ack)                     st_nx = CH_ACK;
            CH_ACK:  if (wr && !wr_req)           st_nx = CH_DROP;
            CH_DROP: if (!ack)                    st_nx = CH_IDLE;
            default:                              st_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            data_q <= '0;
            err    <= 1'b0;
            req_d  <= 1'b0;
        end else begin
            req_d <= req;
            if (st == CH_IDLE && wr) begin
                type_q <= wr_type;
                data_q <= wr_data;
                if (wr_req && !type_ok) err <= 1'b1;
            end
        end
    end

    assign req  = (st == CH_REQ) || (st == CH_ACK);
    assign rise = req && !req_d;

    mbx_wait_timer #(
        .LIM_FAST(LIM_FAST),
        .LIM_SLOW(LIM_SLOW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow    (slow),
        .waiting ((st == CH_REQ) || (st == CH_DROP)),
        .restart (st_nx != st),
        .tmo     (tmo)
    );

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req && !(wr && !wr_req) |=> req); // R4
    AST_BAD_TYPE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req && wr && wr_req && !type_ok |=> !req); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R8
    AST_REQ_TYPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (type_q[TYPE_W-1] == DEV_INIT)); // R8
    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $stable(type_q) && $stable(data_q)); // R5
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R11
endmodule

// File: rtl/mailbox_xchg.sv
module mailbox_xchg
    import mbx_pkg::*;
#(
    parameter int LIM_FAST = 2_500_000,
    parameter int LIM_SLOW = 55_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_link,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        dev_wr,
    input  logic [31:0] dev_wdata,
    output logic [31:0] dev_rdata,
    output logic        dev_req_pulse,
    output logic        host_evt_pulse,
    output logic        host_err,
    output logic        dev_err,
    output logic        host_tmo,
    output logic        dev_tmo
);
    logic              dev_ack_q;
    logic              host_ack_q;
    logic [BYTE_W-1:0] reply_q;

    logic              h_req, d_req;
    logic [TYPE_W-1:0] h_type, d_type;
    logic [BYTE_W-1:0] h_data, d_data;
    logic              unused_bits;

    assign unused_bits = ^{host_wdata[31:24], host_wdata[22:16], dev_wdata[6:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_ack_q  <= 1'b0;
            host_ack_q <= 1'b0;
            reply_q    <= '0;
        end else begin
            if (dev_wr) begin
                dev_ack_q <= dev_wdata[7];
                reply_q   <= dev_wdata[15:8];
            end
            if (host_wr) host_ack_q <= host_wdata[23];
        end
    end

    mbx_chan #(
        .DEV_INIT (1'b0),
        .LIM_FAST (LIM_FAST),
        .LIM_SLOW (LIM_SLOW)
    ) u_host_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow    (slow_link),
        .wr      (host_wr),
        .wr_req  (host_wdata[7]),
        .wr_type (host_wdata[6:0]),
        .wr_data (host_wdata[15:8]),
        .ack     (dev_ack_q),
        .req     (h_req),
        .type_q  (h_type),
        .data_q  (h_data),
        .rise    (dev_req_pulse),
        .err     (host_err),
        .tmo     (host_tmo)
    );

    mbx_chan #(
        .DEV_INIT (1'b1),
        .LIM_FAST (LIM_FAST),
        .LIM_SLOW (LIM_SLOW)
    ) u_dev_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow    (slow_link),
        .wr      (dev_wr),
        .wr_req  (dev_wdata[23]),
        .wr_type (dev_wdata[22:16]),
        .wr_data (dev_wdata[31:24]),
        .ack     (host_ack_q),
        .req     (d_req),
        .type_q  (d_type),
        .data_q  (d_data),
        .rise    (host_evt_pulse),
        .err     (dev_err),
        .tmo     (dev_tmo)
    );

    assign host_rdata = {d_data, d_req, d_type, reply_q, dev_ack_q, h_type};
    assign dev_rdata  = {d_data, host_ack_q, d_type, h_data, h_req, h_type};
endmodule

// File: tb/mailbox_xchg_tb.sv
module mailbox_xchg_tb;
    localparam int LF = 40;
    localparam int LS = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_link = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dev_wr = 1'b0;
    logic [31:0] dev_wdata = '0;
    logic [31:0] dev_rdata;
    logic        dev_req_pulse, host_evt_pulse;
    logic        host_err, dev_err, host_tmo, dev_tmo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mailbox_xchg #(.LIM_FAST(LF), .LIM_SLOW(LS)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_link(slow_link),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_req_pulse(dev_req_pulse), .host_evt_pulse(host_evt_pulse),
        .host_err(host_err), .dev_err(dev_err),
        .host_tmo(host_tmo), .dev_tmo(dev_tmo)
    );

    function automatic logic [31:0] hword(logic [6:0] t, logic rq, logic [7:0] d, logic ak);
        return {8'h00, ak, 7'h00, d, rq, t};
    endfunction

    function automatic logic [31:0] dword(logic [7:0] d, logic rq, logic [6:0] t,
                                          logic [7:0] rep, logic ak);
        return {d, rq, t, rep, ak, 7'h00};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwr(logic [31:0] w);
        host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic dwr(logic [31:0] w);
        dev_wr = 1'b1; dev_wdata = w;
        @(negedge clk);
        dev_wr = 1'b0; dev_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic host_txn(logic [6:0] t, logic [7:0] d, logic [7:0] r);
        hwr(hword(t, 1'b0, d, 1'b0));
        hwr(hword(t, 1'b1, d, 1'b0));
        chk("R2 device view of host request", {16'h0, dev_rdata[15:0]}, {16'h0, d, 1'b1, t});
        chk("R11 dev_req_pulse high", {31'h0, dev_req_pulse}, 32'h1);
        tick();
        chk("R11 dev_req_pulse one cycle", {31'h0, dev_req_pulse}, 32'h0);
        dwr(dword(8'h00, 1'b0, 7'h00, r, 1'b1));
        chk("R3 host view ack and reply", {16'h0, host_rdata[15:0]}, {16'h0, r, 1'b1, t});
        tick();
        hwr(hword(t, 1'b0, d, 1'b0));
        chk("R4 request withdrawn", {31'h0, dev_rdata[7]}, 32'h0);
        dwr(dword(8'h00, 1'b0, 7'h00, r, 1'b0));
        chk("R3 ack dropped", {31'h0, host_rdata[7]}, 32'h0);
        tick();
    endtask

    task automatic dev_txn(logic [6:0] t, logic [7:0] d);
        dwr(dword(d, 1'b1, t, 8'h00, 1'b0));
        chk("R6 host view of device post", {16'h0, host_rdata[31:16]}, {16'h0, d, 1'b1, t});
        chk("R11 host_evt_pulse high", {31'h0, host_evt_pulse}, 32'h1);
        tick();
        chk("R11 host_evt_pulse one cycle", {31'h0, host_evt_pulse}, 32'h0);
        hwr(hword(7'h00, 1'b0, 8'h00, 1'b1));
        chk("R7 host ack seen by device", {31'h0, dev_rdata[23]}, 32'h1);
        tick();
        dwr(dword(d, 1'b0, t, 8'h00, 1'b0));
        chk("R7 device request withdrawn", {31'h0, host_rdata[23]}, 32'h0);
        hwr(hword(7'h00, 1'b0, 8'h00, 1'b0));
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog (R1..): got hung run expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R1 host view after reset", host_rdata, 32'h0);
        chk("R1 device view after reset", dev_rdata, 32'h0);
        chk("R1 flags after reset",
            {26'h0, dev_req_pulse, host_evt_pulse, host_err, dev_err, host_tmo, dev_tmo}, 32'h0);

        host_txn(7'h00, 8'hA5, 8'h5A);
        host_txn(7'h3F, 8'hFF, 8'h00);
        dev_txn(7'h40, 8'h41);
        dev_txn(7'h7F, 8'h00);
        for (int i = 0; i < 12; i++) begin
            host_txn(7'($urandom_range(0, 63)), 8'($urandom), 8'($urandom));
            dev_txn(7'($urandom_range(64, 127)), 8'($urandom));
        end

        hwr(hword(7'h05, 1'b0, 8'h3C, 1'b0));
        hwr(hword(7'h05, 1'b1, 8'h3C, 1'b0));
        hwr(hword(7'h09, 1'b1, 8'hAA, 1'b0));
        chk("R5 host fields frozen while busy", {16'h0, dev_rdata[15:0]}, {16'h0, 8'h3C, 1'b1, 7'h05});
        hwr(hword(7'h05, 1'b0, 8'h3C, 1'b0));
        chk("R4 early withdraw ignored", {31'h0, dev_rdata[7]}, 32'h1);
        dwr(dword(8'h00, 1'b0, 7'h00, 8'h77, 1'b1));
        tick();
        hwr(hword(7'h05, 1'b0, 8'h3C, 1'b0));
        chk("R4 request held until ack fall", {31'h0, dev_rdata[7]}, 32'h0);
        dwr(dword(8'h00, 1'b0, 7'h00, 8'h77, 1'b0));
        tick();

        dwr(dword(8'h21, 1'b1, 7'h42, 8'h00, 1'b0));
        dwr(dword(8'h99, 1'b1, 7'h50, 8'h00, 1'b0));
        chk("R5 device fields frozen while busy", {16'h0, host_rdata[31:16]}, {16'h0, 8'h21, 1'b1, 7'h42});
        hwr(hword(7'h00, 1'b0, 8'h00, 1'b1));
        tick();
        dwr(dword(8'h21, 1'b0, 7'h42, 8'h00, 1'b0));
        hwr(hword(7'h00, 1'b0, 8'h00, 1'b0));
        tick();
        chk("R1 no stray errors", {30'h0, host_err, dev_err}, 32'h0);

        hwr(hword(7'h45, 1'b1, 8'h12, 1'b0));
        chk("R8 host bad type flagged", {31'h0, host_err}, 32'h1);
        chk("R8 host bad type not raised", {31'h0, dev_rdata[7]}, 32'h0);
        dwr(dword(8'h11, 1'b1, 7'h12, 8'h00, 1'b0));
        chk("R8 device bad type flagged", {31'h0, dev_err}, 32'h1);
        chk("R8 device bad type not raised", {31'h0, host_rdata[23]}, 32'h0);
        tick(2);
        chk("R8 errors sticky", {30'h0, host_err, dev_err}, 32'h3);

        slow_link = 1'b1;
        do_reset();
        hwr(hword(7'h03, 1'b1, 8'h00, 1'b0));
        tick(100);
        chk("R10 slow limit not yet reached", {31'h0, host_tmo}, 32'h0);
        tick(150);
        chk("R10 slow limit reached", {31'h0, host_tmo}, 32'h1);

        slow_link = 1'b0;
        do_reset();
        hwr(hword(7'h03, 1'b1, 8'h00, 1'b0));
        tick(20);
        chk("R9 fast limit not yet reached", {31'h0, host_tmo}, 32'h0);
        tick(40);
        chk("R9 fast limit reached", {31'h0, host_tmo}, 32'h1);
        dwr(dword(8'h01, 1'b1, 7'h41, 8'h00, 1'b0));
        tick(20);
        chk("R9 device wait below limit", {31'h0, dev_tmo}, 32'h0);
        tick(40);
        chk("R9 device wait timed out", {31'h0, dev_tmo}, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule